// File: doc/BRIEF.md
# UART Modem Control and Loopback

This block sits between a 16550-style UART core and the modem handshake pins. It holds the modem control register (the handshake outputs, an auxiliary output, the interrupt-enable output and the loopback switch). It also holds the modem status register, which shows the four handshake inputs and their change flags. The four active-low input pins pass through a two-flop synchronizer. Inside the block every status bit is active-high.

In normal operation the control bits drive the active-low output pins. The transmitter's serial bit goes out on the transmit pin, and the receive pin feeds the receiver. In loopback the transmit pin idles high and all four control pins go inactive. The receiver is then fed from the transmitter, so data and break conditions return at once. The status bits are taken from the control bits rather than from the pins, which lets software exercise the modem interrupt by writing the control register.

The combined UART interrupt is the core's own request ORed with the modem-change request, and the result is gated by the interrupt-enable control bit. Software reads the status register to clear the change flags. This also covers the spurious flags that can appear on leaving loopback.

Top module: `uart_modem_ctl`

## Requirements
- R1: After reset the control register reads 00h and the status register reads 00h. All four control pins are high, and both interrupt outputs are low while the core request is low.
- R2: Control bit positions are: 0 = DTR, 1 = RTS, 2 = OUT1, 3 = OUT2, 4 = LOOP. Bits 7:5 ignore writes and read as 0, so writing FFh reads back 1Fh.
- R3: When LOOP is 0, each control bit drives its pin low when the bit is 1 and high when it is 0. `pin_txd` follows `tx_serial_in`, and `rx_serial_out` follows `pin_rxd`.
- R4: When LOOP is 1, `pin_txd` is 1 and all four control pins are 1. `rx_serial_out` follows `tx_serial_in` and ignores `pin_rxd`.
- R5: When LOOP is 0, status bits 4, 5, 6 and 7 (CTS, DSR, RI, DCD) are the inverses of the CTS, DSR, RI and DCD pins. A pin change shows in the status read on the third rising edge after it, and not on the second.
- R6: When LOOP is 1, the status bits follow the control bits one edge after the write: RTS to CTS (bit 4), DTR to DSR (bit 5), OUT1 to RI (bit 6) and OUT2 to DCD (bit 7). The input pins are ignored.
- R7: Delta bits are: bit 0 on any CTS change, bit 1 on any DSR change, bit 3 on any DCD change, and bit 2 only on a 1-to-0 change of RI.
- R8: A read of the status register returns the current flags and clears bits 3:0 on that clock edge.
- R9: `modem_irq` is high exactly while any of status bits 3:0 is set.
- R10: `uart_irq` equals OUT2 AND (`core_irq` OR `modem_irq`).
- R11: A write to the status address (address 1) changes neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | 1 | 0 = control register, 1 = status register |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (clears status flags at address 1) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the addressed register |
| tx_serial_in | input | 1 | Serial bit from the transmitter shift register |
| rx_serial_out | output | 1 | Serial bit to the receiver shift register |
| pin_txd | output | 1 | Serial transmit pin |
| pin_rxd | input | 1 | Serial receive pin |
| pin_rts_n | output | 1 | Request-to-send, active low |
| pin_dtr_n | output | 1 | Data-terminal-ready, active low |
| pin_out1_n | output | 1 | Auxiliary output, active low |
| pin_out2_n | output | 1 | Interrupt-enable output, active low |
| pin_cts_n | input | 1 | Clear-to-send, active low |
| pin_dsr_n | input | 1 | Data-set-ready, active low |
| pin_dcd_n | input | 1 | Carrier detect, active low |
| pin_ri_n | input | 1 | Ring indicator, active low |
| core_irq | input | 1 | Transmit/receive/line interrupt request from the core |
| modem_irq | output | 1 | Modem status change request |
| uart_irq | output | 1 | Combined interrupt, gated by OUT2 |

## Verification
The assertions assume that the register strobes and address are stable across each rising edge. They also assume that pin changes come no faster than one per edge, so that each change reaches the status register as a single transition. The bench drives every input on the falling edge only. It holds each pin level for at least three edges before it checks, so that every change has passed through the synchronizer and the status register. It clears the change flags after each scenario, and it re-checks the status register before and after toggling pins in loopback to show that they are ignored.

// File: rtl/umc_pkg.sv
package umc_pkg;
    localparam int REG_W   = 8;
    localparam int CTL_W   = 5;
    localparam int LINES_W = 4;
    localparam int DELTA_W = 4;

    // Control bit order: DTR at bit 0 up to LOOP at bit 4
    typedef struct packed {
        logic loop;
        logic out2;
        logic out1;
        logic rts;
        logic dtr;
    } ctl_t;

    // Line order matches status bits 7:4
    typedef struct packed {
        logic dcd;
        logic ri;
        logic dsr;
        logic cts;
    } lines_t;
endpackage

// File: rtl/umc_sync.sv
module umc_sync #(
    parameter int WIDTH              = 4,
    parameter int STAGES             = 2,
    parameter logic [WIDTH-1:0] INIT = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0][WIDTH-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[g] <= INIT;
                else        chain_q[g] <= chain_d[g];
            end
        end
    endgenerate

    assign dout = chain_q[LAST];
endmodule

// File: rtl/umc_ctl_reg.sv
module umc_ctl_reg
    import umc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wdata,
    output ctl_t             ctl
);
    typedef struct packed {
        ctl_t ctl;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            // Upper reserved bits are dropped here
            st_d.ctl = ctl_t'(wdata[CTL_W-1:0]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctl = st_q.ctl;
endmodule

// File: rtl/umc_status.sv
module umc_status
    import umc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  ctl_t             ctl,
    input  lines_t           pin_lines,
    input  logic             clr,
    output logic [REG_W-1:0] status
);
    typedef struct packed {
        lines_t               lines;
        logic [DELTA_W-1:0]   delta;
    } state_t;

    state_t             st_d, st_q;
    lines_t             cur;
    logic [DELTA_W-1:0] ev;

    always_comb begin
        // In loopback the lines come from the control bits
        if (ctl.loop) begin
            cur.cts = ctl.rts;
            cur.dsr = ctl.dtr;
            cur.ri  = ctl.out1;
            cur.dcd = ctl.out2;
        end else begin
            cur = pin_lines;
        end

        ev[0] = cur.cts ^ st_q.lines.cts;
        ev[1] = cur.dsr ^ st_q.lines.dsr;
        ev[2] = st_q.lines.ri & ~cur.ri;
        ev[3] = cur.dcd ^ st_q.lines.dcd;

        st_d       = st_q;
        st_d.lines = cur;
        st_d.delta = (clr ? '0 : st_q.delta) | ev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status = {st_q.lines, st_q.delta};
endmodule

// File: rtl/umc_route.sv
module umc_route
    import umc_pkg::*;
(
    input  ctl_t               ctl,
    input  logic [DELTA_W-1:0] delta,
    input  logic               tx_serial_in,
    input  logic               pin_rxd,
    input  logic               core_irq,
    output logic               pin_txd,
    output logic               rx_serial_out,
    output logic               pin_rts_n,
    output logic               pin_dtr_n,
    output logic               pin_out1_n,
    output logic               pin_out2_n,
    output logic               modem_irq,
    output logic               uart_irq
);
    always_comb begin
        if (ctl.loop) begin
            pin_txd       = 1'b1;
            rx_serial_out = tx_serial_in;
            pin_rts_n     = 1'b1;
            pin_dtr_n     = 1'b1;
            pin_out1_n    = 1'b1;
            pin_out2_n    = 1'b1;
        end else begin
            pin_txd       = tx_serial_in;
            rx_serial_out = pin_rxd;
            pin_rts_n     = ~ctl.rts;
            pin_dtr_n     = ~ctl.dtr;
            pin_out1_n    = ~ctl.out1;
            pin_out2_n    = ~ctl.out2;
        end
        modem_irq = |delta;
        uart_irq  = ctl.out2 & (core_irq | modem_irq);
    end
endmodule

// File: rtl/uart_modem_ctl.sv
module uart_modem_ctl
    import umc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_addr,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             tx_serial_in,
    output logic             rx_serial_out,
    output logic             pin_txd,
    input  logic             pin_rxd,
    output logic             pin_rts_n,
    output logic             pin_dtr_n,
    output logic             pin_out1_n,
    output logic             pin_out2_n,
    input  logic             pin_cts_n,
    input  logic             pin_dsr_n,
    input  logic             pin_dcd_n,
    input  logic             pin_ri_n,
    input  logic             core_irq,
    output logic             modem_irq,
    output logic             uart_irq
);
    localparam int RSV_W = REG_W - CTL_W;

    ctl_t               ctl;
    lines_t             raw_n, synced_n, pin_lines;
    logic [REG_W-1:0]   status_bits;
    logic [CTL_W-1:0]   ctl_bits;
    logic               wr_ctl, rd_status;

    assign wr_ctl    = reg_wr & ~reg_addr;
    assign rd_status = reg_rd & reg_addr;

    assign raw_n.cts = pin_cts_n;
    assign raw_n.dsr = pin_dsr_n;
    assign raw_n.ri  = pin_ri_n;
    assign raw_n.dcd = pin_dcd_n;

    umc_sync #(.WIDTH(LINES_W), .STAGES(SYNC_STAGES), .INIT('1)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (raw_n),
        .dout (synced_n)
    );

    assign pin_lines = ~synced_n;

    umc_ctl_reg u_ctl (
        .clk  (clk),
        .rst_n(rst_n),
        .wr_en(wr_ctl),
        .wdata(reg_wdata),
        .ctl  (ctl)
    );

    umc_status u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctl      (ctl),
        .pin_lines(pin_lines),
        .clr      (rd_status),
        .status   (status_bits)
    );

    umc_route u_route (
        .ctl          (ctl),
        .delta        (status_bits[DELTA_W-1:0]),
        .tx_serial_in (tx_serial_in),
        .pin_rxd      (pin_rxd),
        .core_irq     (core_irq),
        .pin_txd      (pin_txd),
        .rx_serial_out(rx_serial_out),
        .pin_rts_n    (pin_rts_n),
        .pin_dtr_n    (pin_dtr_n),
        .pin_out1_n   (pin_out1_n),
        .pin_out2_n   (pin_out2_n),
        .modem_irq    (modem_irq),
        .uart_irq     (uart_irq)
    );

    assign ctl_bits  = ctl;
    assign reg_rdata = reg_addr ? status_bits : {{RSV_W{1'b0}}, ctl_bits};
endmodule

// File: rtl/umc_checker.sv
module umc_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [4:0] ctl,
    input logic [7:0] status,
    input logic       reg_addr,
    input logic [7:0] reg_rdata,
    input logic       tx_serial_in,
    input logic       rx_serial_out,
    input logic       pin_txd,
    input logic       pin_rts_n,
    input logic       pin_dtr_n,
    input logic       pin_out1_n,
    input logic       pin_out2_n,
    input logic       modem_irq,
    input logic       uart_irq
);
    p_loop_pins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ctl[4] |-> (pin_txd && pin_rts_n && pin_dtr_n && pin_out1_n && pin_out2_n));

    p_loop_rx_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ctl[4] |-> (rx_serial_out == tx_serial_in));

    p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_addr |-> (reg_rdata[7:5] == 3'b000));

    p_loop_map_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ctl[4]) |-> (status[7:4] ==
            {$past(ctl[3]), $past(ctl[2]), $past(ctl[0]), $past(ctl[1])}));

    p_teri_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[2]) |-> ($past(status[6]) && !status[6]));

    p_modem_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
        modem_irq == (status[3:0] != 4'h0));

    p_out2_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl[3] |-> !uart_irq);
endmodule

bind uart_modem_ctl umc_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ctl          (ctl_bits),
    .status       (status_bits),
    .reg_addr     (reg_addr),
    .reg_rdata    (reg_rdata),
    .tx_serial_in (tx_serial_in),
    .rx_serial_out(rx_serial_out),
    .pin_txd      (pin_txd),
    .pin_rts_n    (pin_rts_n),
    .pin_dtr_n    (pin_dtr_n),
    .pin_out1_n   (pin_out1_n),
    .pin_out2_n   (pin_out2_n),
    .modem_irq    (modem_irq),
    .uart_irq     (uart_irq)
);

// File: tb/sim_uart_modem_ctl.sv
module sim_uart_modem_ctl;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_addr = 1'b0, reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       tx_serial_in = 1'b1, rx_serial_out, pin_txd, pin_rxd = 1'b1;
    logic       pin_rts_n, pin_dtr_n, pin_out1_n, pin_out2_n;
    logic       pin_cts_n = 1'b1, pin_dsr_n = 1'b1, pin_dcd_n = 1'b1, pin_ri_n = 1'b1;
    logic       core_irq = 1'b0, modem_irq, uart_irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_modem_ctl u0 (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .tx_serial_in(tx_serial_in), .rx_serial_out(rx_serial_out),
        .pin_txd(pin_txd), .pin_rxd(pin_rxd), .pin_rts_n(pin_rts_n),
        .pin_dtr_n(pin_dtr_n), .pin_out1_n(pin_out1_n), .pin_out2_n(pin_out2_n),
        .pin_cts_n(pin_cts_n), .pin_dsr_n(pin_dsr_n), .pin_dcd_n(pin_dcd_n),
        .pin_ri_n(pin_ri_n), .core_irq(core_irq), .modem_irq(modem_irq),
        .uart_irq(uart_irq)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] ctl_pins();
        return {pin_out2_n, pin_out1_n, pin_rts_n, pin_dtr_n};
    endfunction

    task automatic wr(input logic a, input logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic peek(input logic a, output logic [7:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic rd_clear(output logic [7:0] d);
        reg_addr = 1'b1; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    task automatic flush();
        logic [7:0] d;
        settle();
        rd_clear(d);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        peek(1'b0, d); chk("R1 ctl after reset", d, 8'h00);
        peek(1'b1, d); chk("R1 status after reset", d, 8'h00);
        chk("R1 ctl pins after reset", {4'h0, ctl_pins()}, 8'h0F);
        chk("R1 irqs after reset", {6'h0, modem_irq, uart_irq}, 8'h00);
    endtask

    task automatic t_ctl_rw();
        logic [7:0] d;
        wr(1'b0, 8'hFF);
        peek(1'b0, d); chk("R2 reserved bits read 0", d, 8'h1F);
        wr(1'b0, 8'hA5);
        peek(1'b0, d); chk("R2 readback", d, 8'h05);
        wr(1'b0, 8'h00);
        flush();
    endtask

    task automatic t_normal_pins();
        wr(1'b0, 8'h0B);
        chk("R3 pins for 0Bh", {4'h0, ctl_pins()}, 8'h04);
        wr(1'b0, 8'h04);
        chk("R3 pins for 04h", {4'h0, ctl_pins()}, 8'h0B);
        tx_serial_in = 1'b0; pin_rxd = 1'b1; #1;
        chk("R3 txd follows tx", {7'h0, pin_txd}, 8'h00);
        chk("R3 rx follows pin", {7'h0, rx_serial_out}, 8'h01);
        pin_rxd = 1'b0; #1;
        chk("R3 rx follows pin low", {7'h0, rx_serial_out}, 8'h00);
        tx_serial_in = 1'b1; pin_rxd = 1'b1;
        wr(1'b0, 8'h00);
        flush();
    endtask

    task automatic t_loop_path();
        wr(1'b0, 8'h1F);
        tx_serial_in = 1'b0; pin_rxd = 1'b1; #1;
        chk("R4 txd idle high", {7'h0, pin_txd}, 8'h01);
        chk("R4 rx from tx (0)", {7'h0, rx_serial_out}, 8'h00);
        chk("R4 ctl pins inactive", {4'h0, ctl_pins()}, 8'h0F);
        tx_serial_in = 1'b1; pin_rxd = 1'b0; #1;
        chk("R4 rx from tx (1)", {7'h0, rx_serial_out}, 8'h01);
        pin_rxd = 1'b1;
        wr(1'b0, 8'h00);
        flush();
    endtask

    task automatic t_status_normal();
        logic [7:0] d;
        pin_cts_n = 1'b0; pin_dsr_n = 1'b0;
        repeat (2) @(negedge clk);
        peek(1'b1, d); chk("R5 not visible after two edges", d, 8'h00);
        @(negedge clk);
        peek(1'b1, d); chk("R5 R7 cts dsr active", d, 8'h33);
        chk("R9 modem irq set", {7'h0, modem_irq}, 8'h01);
        rd_clear(d); chk("R8 read returns flags", d, 8'h33);
        peek(1'b1, d); chk("R8 flags cleared", d, 8'h30);
        chk("R9 modem irq clear", {7'h0, modem_irq}, 8'h00);
        pin_ri_n = 1'b0; settle();
        peek(1'b1, d); chk("R7 ri rising no flag", d, 8'h70);
        pin_ri_n = 1'b1; settle();
        peek(1'b1, d); chk("R7 ri falling flag", d, 8'h34);
        pin_dcd_n = 1'b0; settle();
        peek(1'b1, d); chk("R7 dcd flag", d, 8'hBC);
        rd_clear(d);
        pin_cts_n = 1'b1; pin_dsr_n = 1'b1; pin_dcd_n = 1'b1;
        flush();
        peek(1'b1, d); chk("R5 idle after release", d, 8'h00);
    endtask

    task automatic t_loop_status();
        logic [7:0] d;
        pin_cts_n = 1'b0; pin_dsr_n = 1'b0; pin_dcd_n = 1'b0; pin_ri_n = 1'b0;
        flush();
        wr(1'b0, 8'h15);
        @(negedge clk);
        peek(1'b1, d); chk("R6 dtr/out1 map", d, 8'h69);
        rd_clear(d);
        wr(1'b0, 8'h1A);
        @(negedge clk);
        peek(1'b1, d); chk("R6 rts/out2 map", d, 8'h9F);
        chk("R6 modem irq from ctl", {7'h0, modem_irq}, 8'h01);
        rd_clear(d);
        pin_cts_n = 1'b1; pin_dsr_n = 1'b1; pin_dcd_n = 1'b1; pin_ri_n = 1'b1;
        repeat (4) @(negedge clk);
        peek(1'b1, d); chk("R6 pins ignored", d, 8'h90);
        wr(1'b0, 8'h00);
        flush();
        peek(1'b1, d); chk("R6 exit loop clean", d, 8'h00);
    endtask

    task automatic t_irq_gate();
        logic [7:0] d;
        core_irq = 1'b1; #1;
        chk("R10 gated off", {7'h0, uart_irq}, 8'h00);
        wr(1'b0, 8'h08);
        chk("R10 core irq passes", {7'h0, uart_irq}, 8'h01);
        core_irq = 1'b0; #1;
        chk("R10 no request", {7'h0, uart_irq}, 8'h00);
        pin_cts_n = 1'b0; settle();
        chk("R10 modem irq passes", {6'h0, modem_irq, uart_irq}, 8'h03);
        wr(1'b0, 8'h00);
        chk("R10 modem irq gated", {6'h0, modem_irq, uart_irq}, 8'h02);
        rd_clear(d);
        pin_cts_n = 1'b1;
        flush();
    endtask

    task automatic t_status_wr();
        logic [7:0] s0, s1, c1;
        wr(1'b0, 8'h02);
        pin_dsr_n = 1'b0; settle();
        peek(1'b1, s0);
        wr(1'b1, 8'hFF);
        peek(1'b1, s1); chk("R11 status unchanged", s1, s0);
        peek(1'b0, c1); chk("R11 ctl unchanged", c1, 8'h02);
        pin_dsr_n = 1'b1;
        wr(1'b0, 8'h00);
        flush();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ctl_rw();
        t_normal_pins();
        t_loop_path();
        t_status_normal();
        t_loop_status();
        t_irq_gate();
        t_status_wr();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule